// File: doc/BRIEF.md
# Accumulator ALU with flags

This block is the arithmetic and logic stage of an accumulator-style 8-bit datapath. On each cycle it takes the accumulator value and a second operand, and an operation code chooses what happens to them. The result is combinational and appears on the same cycle. A separate output says whether the accumulator should take the result. The block also computes an updated condition-flag byte. That byte is held in an internal flag register, which loads on a clock edge while the flag-write enable is high.

Every operation either updates each of the five flags or leaves it unchanged. The operations are add, add with carry, subtract, subtract with borrow, increment, decrement, AND, OR, XOR, complement, compare, four rotates, complement carry and set carry. The stored flag byte is read back on `flags_o`. The carry inside it is the carry-in for the carry-aware operations.

Top module: `acc_alu_top`

## Requirements
- R1: `flags_o` packs carry at bit 0, parity at bit 2, auxiliary carry at bit 4, zero at bit 6 and sign at bit 7. Bits 1, 3 and 5 always read 0.
- R2: When an operation updates sign, zero and parity, the values come from the 8-bit result. Sign is result bit 7, zero is 1 for a result of 0x00, and parity is 1 when the result has an even number of ones.
- R3: ADD (op 0x00) and ADC (op 0x01) give acc + opnd, and ADC also adds the stored carry. Carry is the carry out of bit 7, and auxiliary carry is the carry out of bit 3. All five flags update and result_we_o is 1.
- R4: SUB (op 0x02) and SBB (op 0x03) give acc - opnd, and SBB also subtracts the stored carry. Carry is 1 on a borrow out of bit 7, and auxiliary carry is 1 on a borrow out of the low nibble. All five flags update and result_we_o is 1.
- R5: CMP (op 0x0A) sets all five flags exactly as SUB would, and result_we_o is 0.
- R6: INC (op 0x04) and DEC (op 0x05) add or subtract 1 and keep the stored carry. Auxiliary carry is 1 when INC sees a low nibble of 0xF, or when DEC sees a low nibble of 0x0. Sign, zero and parity update as in R2.
- R7: AND (op 0x06), OR (op 0x07) and XOR (op 0x08) are bitwise. They clear carry and auxiliary carry and update sign, zero and parity.
- R8: CPL (op 0x09) outputs ~acc with result_we_o 1 and changes no flag.
- R9: There are four rotates, and each changes only carry. Rotate left (0x0B) and rotate right (0x0C) wrap bit 7 or bit 0 around the byte and copy that bit into carry. Rotate left through carry (0x0D) and rotate right through carry (0x0E) shift the old carry in and capture the bit shifted out.
- R10: CMC (op 0x0F) inverts carry and STC (op 0x10) sets it. Neither changes another flag, and both drive result_we_o to 0.
- R11: The flag register loads only on a rising clock edge with flag_we_i high. rst_ni low clears it to 0x00 at once, without waiting for a clock.
- R12: Op codes 0x11 to 0x1F drive result_we_o to 0 and leave every flag unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| acc_i | input | 8 | Accumulator operand |
| opnd_i | input | 8 | Second operand |
| op_i | input | 5 | Operation code |
| flag_we_i | input | 1 | Flag register load enable |
| result_o | output | 8 | Operation result |
| result_we_o | output | 1 | Result should be written to the accumulator |
| flags_o | output | 8 | Stored flag byte |

## Verification
The corner that is hardest to reach is where the stored carry changes the outcome. Examples are subtract with borrow when the borrow flows through both nibbles, rotates through carry, and increment or decrement that must keep a carry set earlier. The flag register has no direct load, so the bench reaches these states through the block's own operations. It runs set carry, complement carry or a carrying add first, and then the operation under test. A bench-side model tracks the stored flags across the whole sequence. Writes with the enable low and the unused op codes are then checked to leave the byte unchanged.

// File: rtl/acc_alu_pkg.sv
package acc_alu_pkg;
  localparam int DW  = 8;
  localparam int NW  = DW / 2;
  localparam int OPW = 5;
  localparam int FW  = 8;

  localparam int F_CY = 0;
  localparam int F_P  = 2;
  localparam int F_AC = 4;
  localparam int F_Z  = 6;
  localparam int F_S  = 7;

  typedef enum logic [OPW-1:0] {
    OP_ADD = 5'h00,
    OP_ADC = 5'h01,
    OP_SUB = 5'h02,
    OP_SBB = 5'h03,
    OP_INC = 5'h04,
    OP_DEC = 5'h05,
    OP_AND = 5'h06,
    OP_OR  = 5'h07,
    OP_XOR = 5'h08,
    OP_CPL = 5'h09,
    OP_CMP = 5'h0A,
    OP_ROL = 5'h0B,
    OP_ROR = 5'h0C,
    OP_RLC = 5'h0D,
    OP_RRC = 5'h0E,
    OP_CMC = 5'h0F,
    OP_STC = 5'h10
  } alu_op_e;

  typedef struct packed {
    logic s;
    logic z;
    logic ac;
    logic p;
    logic cy;
  } flag_sel_t;

  localparam flag_sel_t UPD_NONE = '{s: 1'b0, z: 1'b0, ac: 1'b0, p: 1'b0, cy: 1'b0};
  localparam flag_sel_t UPD_ALL  = '{s: 1'b1, z: 1'b1, ac: 1'b1, p: 1'b1, cy: 1'b1};
  localparam flag_sel_t UPD_NOCY = '{s: 1'b1, z: 1'b1, ac: 1'b1, p: 1'b1, cy: 1'b0};
  localparam flag_sel_t UPD_CY   = '{s: 1'b0, z: 1'b0, ac: 1'b0, p: 1'b0, cy: 1'b1};
endpackage

// File: rtl/alu_arith.sv
module alu_arith #(
  parameter int W = 8
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         cin_i,
  input  logic         sub_i,
  output logic [W-1:0] res_o,
  output logic         cy_o,
  output logic         ac_o
);
  localparam int HW = W / 2;

  logic [HW:0] lo;
  logic [W:0]  full;

  // borrow shows up as the wrapped top bit in subtract mode
  always_comb begin
    if (sub_i) begin
      lo   = {1'b0, a_i[HW-1:0]} - {1'b0, b_i[HW-1:0]} - {{HW{1'b0}}, cin_i};
      full = {1'b0, a_i} - {1'b0, b_i} - {{W{1'b0}}, cin_i};
    end else begin
      lo   = {1'b0, a_i[HW-1:0]} + {1'b0, b_i[HW-1:0]} + {{HW{1'b0}}, cin_i};
      full = {1'b0, a_i} + {1'b0, b_i} + {{W{1'b0}}, cin_i};
    end
  end

  assign res_o = full[W-1:0];
  assign cy_o  = full[W];
  assign ac_o  = lo[HW];
endmodule

// File: rtl/alu_logic.sv
module alu_logic
  import acc_alu_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         cy_i,
  input  alu_op_e      op_i,
  output logic [W-1:0] res_o,
  output logic         cy_o
);
  always_comb begin
    res_o = a_i;
    cy_o  = cy_i;
    unique case (op_i)
      OP_AND: res_o = a_i & b_i;
      OP_OR:  res_o = a_i | b_i;
      OP_XOR: res_o = a_i ^ b_i;
      OP_CPL: res_o = ~a_i;
      OP_ROL: begin
        res_o = {a_i[W-2:0], a_i[W-1]};
        cy_o  = a_i[W-1];
      end
      OP_ROR: begin
        res_o = {a_i[0], a_i[W-1:1]};
        cy_o  = a_i[0];
      end
      OP_RLC: begin
        res_o = {a_i[W-2:0], cy_i};
        cy_o  = a_i[W-1];
      end
      OP_RRC: begin
        res_o = {cy_i, a_i[W-1:1]};
        cy_o  = a_i[0];
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/alu_flag_gen.sv
module alu_flag_gen
  import acc_alu_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [W-1:0]  res_i,
  input  logic          ac_i,
  input  logic          cy_i,
  input  flag_sel_t     upd_i,
  input  logic [FW-1:0] cur_i,
  output logic [FW-1:0] nxt_o
);
  localparam logic [FW-1:0] USED = FW'((1 << F_S) | (1 << F_Z) | (1 << F_AC) | (1 << F_P) | (1 << F_CY));

  logic [FW-1:0] tmp;

  always_comb begin
    tmp = cur_i;
    if (upd_i.s)  tmp[F_S]  = res_i[W-1];
    if (upd_i.z)  tmp[F_Z]  = (res_i == '0);
    if (upd_i.ac) tmp[F_AC] = ac_i;
    if (upd_i.p)  tmp[F_P]  = ~^res_i;
    if (upd_i.cy) tmp[F_CY] = cy_i;
    nxt_o = tmp & USED;
  end
endmodule

// File: rtl/flag_reg.sv
module flag_reg #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         we_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   q_o <= '0;
    else if (we_i) q_o <= d_i;
  end
endmodule

// File: rtl/acc_alu_top.sv
module acc_alu_top
  import acc_alu_pkg::*;
(
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic [DW-1:0]  acc_i,
  input  logic [DW-1:0]  opnd_i,
  input  logic [OPW-1:0] op_i,
  input  logic           flag_we_i,
  output logic [DW-1:0]  result_o,
  output logic           result_we_o,
  output logic [FW-1:0]  flags_o
);
  alu_op_e       op;
  logic          cur_cy;
  logic [DW-1:0] ar_b;
  logic          ar_cin, ar_sub;
  logic [DW-1:0] ar_res, lg_res;
  logic          ar_cy, ar_ac, lg_cy;
  logic          use_arith;
  logic          cy_new, ac_new;
  flag_sel_t     upd;
  logic [FW-1:0] flags_nxt;

  assign op     = alu_op_e'(op_i);
  assign cur_cy = flags_o[F_CY];

  always_comb begin
    ar_b        = opnd_i;
    ar_cin      = 1'b0;
    ar_sub      = 1'b0;
    use_arith   = 1'b0;
    result_we_o = 1'b0;
    upd         = UPD_NONE;
    cy_new      = ar_cy;
    ac_new      = ar_ac;
    unique case (op)
      OP_ADD: begin use_arith = 1'b1; result_we_o = 1'b1; upd = UPD_ALL; end
      OP_ADC: begin use_arith = 1'b1; ar_cin = cur_cy; result_we_o = 1'b1; upd = UPD_ALL; end
      OP_SUB: begin use_arith = 1'b1; ar_sub = 1'b1; result_we_o = 1'b1; upd = UPD_ALL; end
      OP_SBB: begin
        use_arith = 1'b1; ar_sub = 1'b1; ar_cin = cur_cy;
        result_we_o = 1'b1; upd = UPD_ALL;
      end
      OP_INC: begin
        use_arith = 1'b1; ar_b = DW'(1); result_we_o = 1'b1; upd = UPD_NOCY;
      end
      OP_DEC: begin
        use_arith = 1'b1; ar_sub = 1'b1; ar_b = DW'(1);
        result_we_o = 1'b1; upd = UPD_NOCY;
      end
      OP_CMP: begin use_arith = 1'b1; ar_sub = 1'b1; upd = UPD_ALL; end
      OP_AND, OP_OR, OP_XOR: begin
        result_we_o = 1'b1; upd = UPD_ALL; cy_new = 1'b0; ac_new = 1'b0;
      end
      OP_CPL: result_we_o = 1'b1;
      OP_ROL, OP_ROR, OP_RLC, OP_RRC: begin
        result_we_o = 1'b1; upd = UPD_CY; cy_new = lg_cy;
      end
      OP_CMC: begin upd = UPD_CY; cy_new = ~cur_cy; end
      OP_STC: begin upd = UPD_CY; cy_new = 1'b1; end
      default: ;
    endcase
  end

  alu_arith #(.W(DW)) u_arith (
    .a_i   (acc_i),
    .b_i   (ar_b),
    .cin_i (ar_cin),
    .sub_i (ar_sub),
    .res_o (ar_res),
    .cy_o  (ar_cy),
    .ac_o  (ar_ac)
  );

  alu_logic #(.W(DW)) u_logic (
    .a_i   (acc_i),
    .b_i   (opnd_i),
    .cy_i  (cur_cy),
    .op_i  (op),
    .res_o (lg_res),
    .cy_o  (lg_cy)
  );

  assign result_o = use_arith ? ar_res : lg_res;

  alu_flag_gen #(.W(DW)) u_fgen (
    .res_i (result_o),
    .ac_i  (ac_new),
    .cy_i  (cy_new),
    .upd_i (upd),
    .cur_i (flags_o),
    .nxt_o (flags_nxt)
  );

  flag_reg #(.W(FW)) u_freg (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (flag_we_i),
    .d_i    (flags_nxt),
    .q_o    (flags_o)
  );
endmodule

// File: rtl/acc_alu_chk.sv
module acc_alu_chk
  import acc_alu_pkg::*;
(
  input logic           clk_i,
  input logic           rst_ni,
  input logic [DW-1:0]  acc_i,
  input logic [DW-1:0]  opnd_i,
  input logic [OPW-1:0] op_i,
  input logic           flag_we_i,
  input logic [DW-1:0]  result_o,
  input logic           result_we_o,
  input logic [FW-1:0]  flags_o
);
  // R1
  unused_bits_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flags_o[5] == 1'b0) && (flags_o[3] == 1'b0) && (flags_o[1] == 1'b0));

  // R11
  flags_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !flag_we_i |=> $stable(flags_o));

  // R5
  cmp_no_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == OP_CMP) |-> !result_we_o);

  // R6
  incdec_keep_cy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flag_we_i && ((op_i == OP_INC) || (op_i == OP_DEC)) |=> flags_o[F_CY] == $past(flags_o[F_CY]));

  // R7
  logic_clr_cy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flag_we_i && ((op_i == OP_AND) || (op_i == OP_OR) || (op_i == OP_XOR))
    |=> !flags_o[F_CY] && !flags_o[F_AC]);

  // R2
  add_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flag_we_i && (op_i == OP_ADD) |=> flags_o[F_Z] == ($past(result_o) == '0));

  // R10
  stc_sets_cy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flag_we_i && (op_i == OP_STC) |=> flags_o[F_CY]);

  // R12
  undef_op_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i > OP_STC) |-> !result_we_o ##1 $stable(flags_o));
endmodule

bind acc_alu_top acc_alu_chk u_chk (.*);

// File: tb/tb_acc_alu_top.sv
module tb_acc_alu_top;
  import acc_alu_pkg::*;

  localparam int CLK_PERIOD = 10;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [7:0] acc_i = '0, opnd_i = '0;
  logic [4:0] op_i = '0;
  logic       flag_we_i = 1'b0;
  logic [7:0] result_o, flags_o;
  logic       result_we_o;

  int n_chk = 0;
  int n_fail = 0;
  logic [7:0] model_f = '0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  acc_alu_top dut (.*);

  task automatic chk(input string req, input string what, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %02h expected %02h", req, what, act, exp);
    end
  endtask

  // expected behaviour written from the requirement list
  task automatic ref_op(input logic [4:0] op, input logic [7:0] a, input logic [7:0] b,
                        input logic [7:0] f, output logic [7:0] r, output logic we,
                        output logic [7:0] nf);
    logic s, z, ac, p, cy;
    logic set_szp;
    int c;
    cy = f[0]; ac = f[4]; s = f[7]; z = f[6]; p = f[2];
    c = int'(f[0]);
    r = a; we = 1'b0; set_szp = 1'b0;
    case (op)
      5'h00, 5'h01: begin
        if (op == 5'h00) c = 0;
        r = 8'(int'(a) + int'(b) + c);
        cy = (int'(a) + int'(b) + c) > 255;
        ac = (int'(a[3:0]) + int'(b[3:0]) + c) > 15;
        we = 1'b1; set_szp = 1'b1;
      end
      5'h02, 5'h03, 5'h0A: begin
        if (op != 5'h03) c = 0;
        r = 8'(int'(a) - int'(b) - c);
        cy = int'(a) < int'(b) + c;
        ac = int'(a[3:0]) < int'(b[3:0]) + c;
        we = (op != 5'h0A); set_szp = 1'b1;
      end
      5'h04: begin r = a + 8'd1; ac = (a[3:0] == 4'hF); we = 1'b1; set_szp = 1'b1; end
      5'h05: begin r = a - 8'd1; ac = (a[3:0] == 4'h0); we = 1'b1; set_szp = 1'b1; end
      5'h06: begin r = a & b; cy = 0; ac = 0; we = 1'b1; set_szp = 1'b1; end
      5'h07: begin r = a | b; cy = 0; ac = 0; we = 1'b1; set_szp = 1'b1; end
      5'h08: begin r = a ^ b; cy = 0; ac = 0; we = 1'b1; set_szp = 1'b1; end
      5'h09: begin r = ~a; we = 1'b1; end
      5'h0B: begin r = {a[6:0], a[7]}; cy = a[7]; we = 1'b1; end
      5'h0C: begin r = {a[0], a[7:1]}; cy = a[0]; we = 1'b1; end
      5'h0D: begin r = {a[6:0], f[0]}; cy = a[7]; we = 1'b1; end
      5'h0E: begin r = {f[0], a[7:1]}; cy = a[0]; we = 1'b1; end
      5'h0F: cy = ~f[0];
      5'h10: cy = 1'b1;
      default: ;
    endcase
    if (set_szp) begin
      s = r[7]; z = (r == 8'h00);
      p = 1'b1;
      for (int i = 0; i < 8; i++) p = p ^ r[i];
    end
    nf = {s, z, 1'b0, ac, 1'b0, p, 1'b0, cy};
  endtask

  task automatic run_op(input string req, input logic [4:0] op, input logic [7:0] a,
                        input logic [7:0] b, input logic we);
    logic [7:0] er, enf;
    logic ewe;
    @(negedge clk_i);
    op_i = op; acc_i = a; opnd_i = b; flag_we_i = we;
    #1;
    ref_op(op, a, b, model_f, er, ewe, enf);
    if (ewe) chk(req, "result", result_o, er);
    chk(req, "result_we", {7'b0, result_we_o}, {7'b0, ewe});
    @(posedge clk_i);
    #1;
    if (we) model_f = enf;
    chk(req, "flags", flags_o, model_f);
    flag_we_i = 1'b0;
  endtask

  task automatic t_reset();
    #1;
    chk("R11", "flags in reset", flags_o, 8'h00);
    @(negedge clk_i); rst_ni = 1'b1;
  endtask

  task automatic t_add();
    run_op("R3", OP_ADD, 8'h3A, 8'hC6, 1'b1);
    chk("R1", "packed add flags", flags_o, 8'h55);
    run_op("R3", OP_ADC, 8'h0F, 8'h00, 1'b1);
    run_op("R3", OP_ADD, 8'h40, 8'h40, 1'b1);
    run_op("R2", OP_ADD, 8'h01, 8'h02, 1'b1);
  endtask

  task automatic t_sub();
    run_op("R4", OP_SUB, 8'h10, 8'h01, 1'b1);
    run_op("R4", OP_SUB, 8'h01, 8'h02, 1'b1);
    run_op("R4", OP_SBB, 8'h00, 8'h0F, 1'b1);
    chk("R4", "sbb borrow", flags_o & 8'h11, 8'h11);
  endtask

  task automatic t_cmp();
    run_op("R5", OP_CMP, 8'h55, 8'h55, 1'b1);
    run_op("R5", OP_CMP, 8'h10, 8'h20, 1'b1);
  endtask

  task automatic t_incdec();
    run_op("R10", OP_STC, 8'h00, 8'h00, 1'b1);
    run_op("R6", OP_INC, 8'hFF, 8'h00, 1'b1);
    run_op("R6", OP_DEC, 8'h00, 8'h00, 1'b1);
    run_op("R6", OP_INC, 8'h7E, 8'h00, 1'b1);
  endtask

  task automatic t_logic();
    run_op("R10", OP_STC, 8'h00, 8'h00, 1'b1);
    run_op("R7", OP_AND, 8'hF0, 8'h3C, 1'b1);
    run_op("R7", OP_OR, 8'h00, 8'h00, 1'b1);
    run_op("R7", OP_XOR, 8'hAA, 8'h55, 1'b1);
  endtask

  task automatic t_cpl();
    run_op("R8", OP_CPL, 8'h5A, 8'h00, 1'b1);
    run_op("R8", OP_CPL, 8'h00, 8'h00, 1'b1);
  endtask

  task automatic t_rot();
    run_op("R9", OP_ROL, 8'h81, 8'h00, 1'b1);
    run_op("R9", OP_ROR, 8'h01, 8'h00, 1'b1);
    run_op("R10", OP_CMC, 8'h00, 8'h00, 1'b1);
    run_op("R9", OP_RLC, 8'h80, 8'h00, 1'b1);
    run_op("R9", OP_RRC, 8'h00, 8'h00, 1'b1);
  endtask

  task automatic t_carry_ops();
    run_op("R10", OP_CMC, 8'hFF, 8'hFF, 1'b1);
    run_op("R10", OP_CMC, 8'h00, 8'h00, 1'b1);
    run_op("R10", OP_STC, 8'h00, 8'h00, 1'b1);
  endtask

  task automatic t_hold();
    run_op("R11", OP_ADD, 8'hFF, 8'h01, 1'b0);
    run_op("R11", OP_XOR, 8'h12, 8'h12, 1'b0);
  endtask

  task automatic t_undef();
    run_op("R12", 5'h11, 8'hFF, 8'hFF, 1'b1);
    run_op("R12", 5'h1F, 8'h00, 8'h01, 1'b1);
  endtask

  task automatic t_async_reset();
    run_op("R10", OP_STC, 8'h00, 8'h00, 1'b1);
    @(negedge clk_i);
    #2 rst_ni = 1'b0;
    #1 model_f = '0;
    chk("R11", "async clear", flags_o, 8'h00);
    @(negedge clk_i); rst_ni = 1'b1;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_add();
    t_sub();
    t_cmp();
    t_incdec();
    t_logic();
    t_cpl();
    t_rot();
    t_carry_ops();
    t_hold();
    t_undef();
    t_async_reset();
    run_op("R3", OP_ADC, 8'hFF, 8'h00, 1'b1);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule